// File: doc/BRIEF.md
# Interval Timer Bank

The block holds a set of independent up-counting timer channels (four by default) behind a simple word-addressed register bus. The bus has a write strobe, a read strobe, a byte address and 32-bit write and read data. Each channel advances by one on each cycle in which its own tick input is high. The ticks come from outside and may run at quite different rates, for example a slow real-time tick for one channel and a fast microsecond tick for another. When a channel's count matches its programmed terminal value on a tick, the channel raises a pending flag. That flag can drive the channel's interrupt line.

Software drives a channel mostly through command addresses. Writing the reset, start or stop address performs that action, and the data on the bus is ignored. The other per-channel registers are:

- a mode bit that picks wrapping or one-shot operation;
- the terminal value;
- an interrupt enable;
- an acknowledge register;
- a packed read-only status word and the live count.

One shared register holds a clock-request bit that is valid for all channels. A channel in wrapping mode with the terminal value left at all ones works as a free-running counter that rolls over.

Top module: `interval_timer_bank`

## Requirements
- R1: Channel n owns the byte window starting at n*0x40. Within a window the word offsets are: reset command 0x00, start command 0x04, stop command 0x08, mode 0x0C, status 0x10, count 0x14, terminal 0x18, interrupt enable 0x1C, acknowledge 0x20. The shared register is at 0x100. Command, mode, enable and acknowledge addresses read 0. Unused offsets, addresses above the shared register and addresses with bits [1:0] not zero read 0 and ignore writes.
- R2: A write to the reset command address, whatever the data, clears the count and the pending flag and leaves the channel idle. Mode, interrupt enable and terminal value are kept.
- R3: A write to the start address sets the channel running and a write to the stop address halts it, whatever the data. A halted channel ignores its tick input.
- R4: A running channel whose count is not equal to its terminal value adds one to the count on every cycle its tick is high. The terminal value reads back what was written. After reset the terminal value is all ones.
- R5: In wrapping mode (mode bit 0 = 0), a tick while count equals the terminal value sets the pending flag and returns the count to 0. The period is therefore terminal+1 ticks.
- R6: In one-shot mode (mode bit 0 = 1), a tick while count equals the terminal value sets the pending flag, stops the channel and holds the count at the terminal value. Further ticks do nothing.
- R7: The status word reads {24'b0, pending, interrupt enable, one-shot, running, state[3:0]}, where state is 1 when halted and 2 when running.
- R8: Writing the acknowledge address with bit 7 set clears the pending flag. Bit 7 clear leaves the flag as it is. A match in the same cycle wins over the clear.
- R9: Bit 0 of the interrupt enable register gates the channel's interrupt output. The output is high exactly when the pending flag and the enable are both set.
- R10: Bit 0 of the shared register at 0x100 drives the clock-request output and reads back. It resets to 0.
- R11: Writes and ticks aimed at one channel leave every other channel's count, flags and interrupt unchanged.
- R12: Read data is registered. The word addressed in a read-strobe cycle appears on the read port after the next clock edge and is held until the next read. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_in | input | 4 | Per-channel count-enable pulses |
| irq_out | output | 4 | Per-channel interrupt lines |
| clk_req | output | 1 | Shared clock-request bit |

## Verification
A write or a tick takes effect at the clock edge where it is sampled. The count, the flags, the interrupt lines and the clock-request output all change at that edge. Read data comes one edge later than the read strobe. The bench changes inputs on the falling edge and samples results on the falling edge that follows the edge where they are due. A read is therefore checked one full cycle after its strobe, and an interrupt is checked half a cycle after the tick or write that caused it.

// File: rtl/itb_pkg.sv
package itb_pkg;

  // Word offsets inside one channel window
  localparam logic [3:0] OFS_RESET = 4'h0;
  localparam logic [3:0] OFS_START = 4'h1;
  localparam logic [3:0] OFS_STOP  = 4'h2;
  localparam logic [3:0] OFS_MODE  = 4'h3;
  localparam logic [3:0] OFS_STAT  = 4'h4;
  localparam logic [3:0] OFS_COUNT = 4'h5;
  localparam logic [3:0] OFS_TERM  = 4'h6;
  localparam logic [3:0] OFS_IEN   = 4'h7;
  localparam logic [3:0] OFS_ACK   = 4'h8;

  localparam int WIN_SHIFT   = 6;      // 0x40-byte window per channel
  localparam int SHARED_ADDR = 'h100;  // clock-request register
  localparam int ACK_BIT     = 7;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd1,
    ST_ACTIVE = 4'd2
  } ch_state_e;

  typedef struct packed {
    logic reset;
    logic start;
    logic stop;
    logic mode_wr;
    logic term_wr;
    logic ien_wr;
    logic ack_wr;
  } ch_cmd_t;

  function automatic logic [31:0] pack_status(input logic run, input logic oneshot,
                                              input logic ien, input logic pend);
    ch_state_e st;
    st = run ? ST_ACTIVE : ST_IDLE;
    return {24'h0, pend, ien, oneshot, run, st};
  endfunction

endpackage

// File: rtl/itb_decode.sv
module itb_decode
  import itb_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 9
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output ch_cmd_t           cmd [NCH],
  output logic              ch_area,
  output logic [$clog2(NCH > 1 ? NCH : 2)-1:0] ch_idx,
  output logic [3:0]        ofs,
  output logic              shared_sel
);
  localparam int SEL_W = $clog2(NCH > 1 ? NCH : 2);
  localparam int AREA_END = NCH << WIN_SHIFT;

  logic aligned;

  assign aligned    = (addr[1:0] == 2'b00);
  assign ch_area    = aligned && (int'(addr) < AREA_END);
  assign ch_idx     = addr[WIN_SHIFT +: SEL_W];
  assign ofs        = addr[5:2];
  assign shared_sel = aligned && (int'(addr) == SHARED_ADDR);

  for (genvar g = 0; g < NCH; g++) begin : g_cmd
    logic hit_ch;
    assign hit_ch = wr && ch_area && (ch_idx == SEL_W'(g));
    always_comb begin
      cmd[g].reset   = hit_ch && (ofs == OFS_RESET);
      cmd[g].start   = hit_ch && (ofs == OFS_START);
      cmd[g].stop    = hit_ch && (ofs == OFS_STOP);
      cmd[g].mode_wr = hit_ch && (ofs == OFS_MODE);
      cmd[g].term_wr = hit_ch && (ofs == OFS_TERM);
      cmd[g].ien_wr  = hit_ch && (ofs == OFS_IEN);
      cmd[g].ack_wr  = hit_ch && (ofs == OFS_ACK);
    end
  end

endmodule

// File: rtl/itb_channel.sv
module itb_channel
  import itb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  ch_cmd_t          cmd,
  input  logic [CNT_W-1:0] wr_value,
  input  logic             wr_b0,
  input  logic             wr_ack_b,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] term,
  output logic             run,
  output logic             oneshot,
  output logic             ien,
  output logic             pend,
  output logic             hit,
  output logic             irq
);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  logic advance;

  assign advance = tick && run;
  assign hit     = advance && (count == term);
  assign irq     = pend && ien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      term    <= '1;
      run     <= 1'b0;
      oneshot <= 1'b0;
      ien     <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (cmd.reset) begin
        count <= '0;
        pend  <= 1'b0;
        run   <= 1'b0;
      end else begin
        if (hit) begin
          pend <= 1'b1;
          if (!oneshot) count <= '0;
        end else begin
          if (advance) count <= bump(count);
          if (cmd.ack_wr && wr_ack_b) pend <= 1'b0;
        end
        if (cmd.stop)               run <= 1'b0;
        else if (cmd.start)         run <= 1'b1;
        else if (hit && oneshot)    run <= 1'b0;
      end
      if (cmd.mode_wr) oneshot <= wr_b0;
      if (cmd.ien_wr)  ien     <= wr_b0;
      if (cmd.term_wr) term    <= wr_value;
    end
  end

endmodule

// File: rtl/interval_timer_bank.sv
module interval_timer_bank
  import itb_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    tick_in,
  output logic [NCH-1:0]    irq_out,
  output logic              clk_req
);
  localparam int SEL_W = $clog2(NCH > 1 ? NCH : 2);

  ch_cmd_t          cmd [NCH];
  logic             ch_area;
  logic [SEL_W-1:0] ch_idx;
  logic [3:0]       ofs;
  logic             shared_sel;

  logic [CNT_W-1:0] ch_count [NCH];
  logic [CNT_W-1:0] ch_term  [NCH];
  logic [NCH-1:0]   ch_run, ch_oneshot, ch_ien, ch_pend, ch_hit;

  logic [DATA_W-1:0] rd_word;

  itb_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .wr         (bus_wr),
    .addr       (bus_addr),
    .cmd        (cmd),
    .ch_area    (ch_area),
    .ch_idx     (ch_idx),
    .ofs        (ofs),
    .shared_sel (shared_sel)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    itb_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_in[g]),
      .cmd      (cmd[g]),
      .wr_value (bus_wdata[CNT_W-1:0]),
      .wr_b0    (bus_wdata[0]),
      .wr_ack_b (bus_wdata[ACK_BIT]),
      .count    (ch_count[g]),
      .term     (ch_term[g]),
      .run      (ch_run[g]),
      .oneshot  (ch_oneshot[g]),
      .ien      (ch_ien[g]),
      .pend     (ch_pend[g]),
      .hit      (ch_hit[g]),
      .irq      (irq_out[g])
    );
  end

  // Shared clock-request bit
  always_ff @(posedge clk) begin
    if (!rst_n)                  clk_req <= 1'b0;
    else if (bus_wr && shared_sel) clk_req <= bus_wdata[0];
  end

  // Read selection
  always_comb begin
    rd_word = '0;
    if (ch_area) begin
      for (int i = 0; i < NCH; i++) begin
        if (ch_idx == SEL_W'(i)) begin
          case (ofs)
            OFS_STAT:  rd_word = DATA_W'(pack_status(ch_run[i], ch_oneshot[i],
                                                     ch_ien[i], ch_pend[i]));
            OFS_COUNT: rd_word = DATA_W'(ch_count[i]);
            OFS_TERM:  rd_word = DATA_W'(ch_term[i]);
            default:   rd_word = '0;
          endcase
        end
      end
    end else if (shared_sel) begin
      rd_word = DATA_W'(clk_req);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

endmodule

// File: rtl/itb_checker.sv
module itb_checker #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic              wd0,
  input logic              wd7,
  input logic              clk_req,
  input logic [NCH-1:0]    ch_hit,
  input logic [NCH-1:0]    ch_pend,
  input logic [NCH-1:0]    ch_run,
  input logic [NCH-1:0]    ch_oneshot
);
  localparam int WORD_W = ADDR_W - 2;

  logic              aligned;
  logic [WORD_W-1:0] word;
  assign aligned = (addr[1:0] == 2'b00);
  assign word    = addr[ADDR_W-1:2];

  p_clkreq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && aligned && word == WORD_W'('h40)) |=> (clk_req == $past(wd0)));

  for (genvar i = 0; i < NCH; i++) begin : g_p
    logic rst_w, start_w, ack_w;
    assign rst_w   = wr && aligned && word == WORD_W'(i*16 + 0);
    assign start_w = wr && aligned && word == WORD_W'(i*16 + 1);
    assign ack_w   = wr && aligned && word == WORD_W'(i*16 + 8);

    p_reset_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_w |=> (!ch_pend[i] && !ch_run[i]));

    p_hit_sets_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_hit[i] && !rst_w) |=> ch_pend[i]);

    p_oneshot_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_hit[i] && ch_oneshot[i] && !start_w) |=> !ch_run[i]);

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_w && wd7 && !ch_hit[i]) |=> !ch_pend[i]);
  end

endmodule

bind interval_timer_bank itb_checker #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr         (bus_wr),
  .addr       (bus_addr),
  .wd0        (bus_wdata[0]),
  .wd7        (bus_wdata[7]),
  .clk_req    (clk_req),
  .ch_hit     (ch_hit),
  .ch_pend    (ch_pend),
  .ch_run     (ch_run),
  .ch_oneshot (ch_oneshot)
);

// File: tb/tb_interval_timer_bank.sv
module tb_interval_timer_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_in = '0;
  logic [3:0]  irq_out;
  logic        clk_req;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  interval_timer_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_in(tick_in), .irq_out(irq_out), .clk_req(clk_req)
  );

  // op: 0 write, 1 read+check, 2 ticks (addr = channel, data = count)
  localparam int NV = 35;
  localparam logic [78:0] TBL [NV] = '{
    {2'd1, 9'h090, 32'h0,    32'h01, 4'd7},  // R7 idle after reset
    {2'd0, 9'h098, 32'h3,    32'h0,  4'd4},
    {2'd1, 9'h098, 32'h0,    32'h3,  4'd4},  // R4 terminal readback
    {2'd0, 9'h09C, 32'h1,    32'h0,  4'd9},
    {2'd0, 9'h084, 32'hDEAD, 32'h0,  4'd3},  // R3 start, data ignored
    {2'd1, 9'h090, 32'h0,    32'h52, 4'd7},
    {2'd2, 9'h002, 32'd2,    32'h0,  4'd4},
    {2'd1, 9'h094, 32'h0,    32'h2,  4'd4},
    {2'd2, 9'h002, 32'd2,    32'h0,  4'd5},
    {2'd1, 9'h094, 32'h0,    32'h0,  4'd5},  // R5 wrapped to 0
    {2'd1, 9'h090, 32'h0,    32'hD2, 4'd7},
    {2'd0, 9'h0A0, 32'h7F,   32'h0,  4'd8},
    {2'd1, 9'h090, 32'h0,    32'hD2, 4'd8},  // R8 no bit 7, still pending
    {2'd0, 9'h0A0, 32'h80,   32'h0,  4'd8},
    {2'd1, 9'h090, 32'h0,    32'h52, 4'd8},
    {2'd0, 9'h088, 32'h0,    32'h0,  4'd3},
    {2'd2, 9'h002, 32'd3,    32'h0,  4'd3},
    {2'd1, 9'h094, 32'h0,    32'h0,  4'd3},  // R3 halted ignores ticks
    {2'd0, 9'h08C, 32'h1,    32'h0,  4'd6},
    {2'd0, 9'h084, 32'h0,    32'h0,  4'd6},
    {2'd2, 9'h002, 32'd4,    32'h0,  4'd6},
    {2'd1, 9'h090, 32'h0,    32'hE1, 4'd6},  // R6 stopped, pending
    {2'd1, 9'h094, 32'h0,    32'h3,  4'd6},
    {2'd2, 9'h002, 32'd2,    32'h0,  4'd6},
    {2'd1, 9'h094, 32'h0,    32'h3,  4'd6},
    {2'd0, 9'h080, 32'h1234, 32'h0,  4'd2},
    {2'd1, 9'h090, 32'h0,    32'h61, 4'd2},  // R2 idle, mode/ien kept
    {2'd1, 9'h094, 32'h0,    32'h0,  4'd2},
    {2'd1, 9'h014, 32'h0,    32'h0,  4'd11}, // R11 channel 0 untouched
    {2'd1, 9'h000, 32'h0,    32'h0,  4'd1},  // R1 command reads 0
    {2'd1, 9'h0A4, 32'h0,    32'h0,  4'd1},
    {2'd0, 9'h100, 32'h1,    32'h0,  4'd10},
    {2'd1, 9'h100, 32'h0,    32'h1,  4'd10}, // R10 readback
    {2'd1, 9'h108, 32'h0,    32'h0,  4'd1},
    {2'd1, 9'h102, 32'h0,    32'h0,  4'd1}   // R1 misaligned
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic ticks(input int ch, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_in[ch] = 1'b1;
      @(negedge clk);
      tick_in[ch] = 1'b0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state of the read port, R9 and R10 outputs
    chk("R12", bus_rdata, 32'h0);
    chk("R9", {28'h0, irq_out}, 32'h0);
    chk("R10", {31'h0, clk_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [8:0]  a;
      logic [31:0] d, e;
      logic [3:0]  rq;
      {op, a, d, e, rq} = TBL[i];
      case (op)
        2'd0: wr(a, d);
        2'd1: begin
          rd(a, v);
          chk($sformatf("R%0d", rq), v, e);
        end
        default: ticks(int'(a), int'(d));
      endcase
    end

    chk("R10", {31'h0, clk_req}, 32'h1);

    // R9: interrupt gating on channel 1, terminal 0 wraps every tick
    wr(9'h058, 32'h0);
    wr(9'h044, 32'h0);
    ticks(1, 1);
    chk("R9", {28'h0, irq_out}, 32'h0);
    wr(9'h05C, 32'h1);
    chk("R9", {28'h0, irq_out}, 32'h2);    // R11 other lines stay low
    wr(9'h060, 32'h80);
    chk("R8", {28'h0, irq_out}, 32'h0);

    // R12: read data held until next read
    rd(9'h098, v);
    chk("R12", v, 32'h3);
    wr(9'h098, 32'h7);
    repeat (3) @(negedge clk);
    chk("R12", bus_rdata, 32'h3);
    rd(9'h098, v);
    chk("R4", v, 32'h7);

    // R1: last channel window and reset default terminal
    rd(9'h0D8, v);
    chk("R4", v, 32'hFFFF_FFFF);
    wr(9'h0D8, 32'h5);
    rd(9'h0D8, v);
    chk("R1", v, 32'h5);

    // R10: clear clock request with bit 0 low
    wr(9'h100, 32'h2);
    chk("R10", {31'h0, clk_req}, 32'h0);

    summary();
    $finish;
  end

endmodule